// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers fourteen peripheral interrupt lines into a pending-request register and keeps a matching enable register whose top bit is a global master switch. A rising edge on a source line records a pending flag for that source. The flag is recorded whether or not the source is enabled. A source takes part in arbitration only when its own enable bit and the master bit are both set.

The fourteen sources are grouped onto six processor levels in a fixed arrangement. The block drives the highest active level as a 3-bit code to the processor, where 0 means no request. It never drives level 7, because the non-maskable path does not pass through this block. Software reads the request register, the enable register and their bitwise AND to find the active sources. It changes either register through a write port that sets or clears the bits marked with a 1.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the request register, the enable register, the active view and `ipl` all read zero.
- R2: A rising edge on `src_irq[i]` sets request bit i on that clock edge, whatever the enable bit holds. A line held high does not set the bit again after software clears it.
- R3: A write with `wr_set`=1 sets every register bit whose data bit is 1. A write with `wr_set`=0 clears those bits. Bits whose data bit is 0 keep their value. `wr_sel`=0 selects the request register and `wr_sel`=1 selects the enable register.
- R4: If a rising edge and a software clear hit the same request bit in the same cycle, the bit ends set.
- R5: `act_rd` equals `req_rd & ena_rd`.
- R6: While enable bit 15 (the master) is 0, `ipl` is 0 whatever the other bits hold.
- R7: Each source maps to a level by its bit index: bits 0 to 2 map to level 1, bit 3 to level 2, bits 4 to 6 to level 3, bits 7 to 10 to level 4, bits 11 and 12 to level 5, and bit 13 to level 6.
- R8: `ipl` is the highest level among the sources that are both pending and enabled, with the master set. `ipl` is never 7.
- R9: Request bits 15:14 and enable bit 14 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | 14 | Peripheral interrupt lines, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the request register, 1 selects the enable register |
| wr_set | input | 1 | 1 sets the marked bits, 0 clears them |
| wr_data | input | 16 | Bit mask for the write |
| req_rd | output | 16 | Request register |
| ena_rd | output | 16 | Enable register, master in bit 15 |
| act_rd | output | 16 | Request AND enable |
| ipl | output | 3 | Encoded processor priority level, 0 when idle |

## Verification
The assertions assume that `src_irq` and the write port are synchronous to `clk` and stable around its rising edge. The bench meets this by driving every input on the falling edge. The assertions also assume that a write touches only one register per cycle, which the single `wr_sel` line guarantees. The stimulus sweeps all 16384 request patterns under full enable. It then sweeps each single enable bit against a full request set, and each source with the master off. Directed cycles cover held lines and the case where a rising edge and a clear arrive together.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   localparam int NSRC       = 14;
   localparam int REG_W      = 16;
   localparam int IPL_W      = 3;
   localparam int MASTER_BIT = REG_W - 1;
   localparam int TOP_LVL    = 6;

   // fixed grouping of source index onto processor level
   function automatic logic [IPL_W-1:0] src_level(input int idx);
      logic [IPL_W-1:0] lv;
      if (idx < 3)       lv = 3'd1;
      else if (idx < 4)  lv = 3'd2;
      else if (idx < 7)  lv = 3'd3;
      else if (idx < 11) lv = 3'd4;
      else if (idx < 13) lv = 3'd5;
      else               lv = 3'd6;
      return lv;
   endfunction

   function automatic logic [NSRC-1:0] level_mask(input int lvl);
      logic [NSRC-1:0] m;
      m = '0;
      for (int i = 0; i < NSRC; i++)
         if (int'(src_level(i)) == lvl) m[i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
   parameter int  N          = 14,
   parameter bit  EDGE_MODE  = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lines,
   output logic [N-1:0] hit
);
   generate
      if (EDGE_MODE) begin : g_edge
         logic [N-1:0] prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= '0;
            else        prev_q <= lines;
         end
         for (genvar i = 0; i < N; i++) begin : g_bit
            assign hit[i] = lines[i] & ~prev_q[i];
         end

         // R2: a pulse is reported only on a fresh rise
         assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (hit != '0) |=> ((hit & $past(hit)) == '0));
      end else begin : g_level
         assign hit = lines;
      end
   endgenerate
endmodule

// File: rtl/irq_setclr_reg.sv
module irq_setclr_reg #(
   parameter int            W     = 16,
   parameter logic [W-1:0]  VALID = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic         wr_set,
   input  logic [W-1:0] wr_mask,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] q
);
   logic [W-1:0] set_v, clr_v, nxt;

   always_comb begin
      set_v = hw_set;
      clr_v = '0;
      if (wr_en) begin
         if (wr_set) set_v = set_v | wr_mask;
         else        clr_v = wr_mask;
      end
      // hardware set overrides software clear
      nxt = ((q & ~clr_v) | set_v) & VALID;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   // R2 / R4: a hardware set always lands, even against a clear
   assert_hw_set_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((hw_set & VALID) != '0) |=> ((q & $past(hw_set & VALID)) == $past(hw_set & VALID)));

   // R3: cleared bits without a competing set go to zero
   assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_set) |=> ((q & $past(wr_mask & ~hw_set)) == '0));

   // R3: set bits appear
   assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_set) |=> ((q & $past(wr_mask & VALID)) == $past(wr_mask & VALID)));

   // R9: unimplemented bits stay zero
   assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (q & ~VALID) == '0);
endmodule

// File: rtl/irq_level_encoder.sv
module irq_level_encoder
   import irq_prio_pkg::*;
#(
   parameter int N_SRC = NSRC,
   parameter int LVLS  = TOP_LVL,
   parameter int OUT_W = IPL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] pend,
   input  logic             master,
   output logic [OUT_W-1:0] ipl
);
   logic [LVLS:1] lvl_hit;

   generate
      for (genvar l = 1; l <= LVLS; l++) begin : g_lvl
         localparam logic [N_SRC-1:0] LMASK = level_mask(l);
         assign lvl_hit[l] = master & (|(pend & LMASK));
      end
   endgenerate

   always_comb begin
      ipl = '0;
      for (int l = 1; l <= LVLS; l++)
         if (lvl_hit[l]) ipl = OUT_W'(l);
   end

   // R6: master off silences the output
   assert_master_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !master |-> (ipl == '0));
   // R8: level 7 never produced
   assert_no_nmi_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ipl != 3'd7);
   // R8: a nonzero level needs some active source
   assert_level_backed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ipl != '0) |-> (pend != '0));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_prio_pkg::*;
#(
   parameter int N_SRC     = NSRC,
   parameter int RW        = REG_W,
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_irq,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic             wr_set,
   input  logic [RW-1:0]    wr_data,
   output logic [RW-1:0]    req_rd,
   output logic [RW-1:0]    ena_rd,
   output logic [RW-1:0]    act_rd,
   output logic [IPL_W-1:0] ipl
);
   localparam int             MBIT      = RW - 1;
   localparam logic [RW-1:0]  SRC_MASK  = RW'((64'd1 << N_SRC) - 64'd1);
   localparam logic [RW-1:0]  ENA_MASK  = SRC_MASK | (RW'(1) << MBIT);

   generate
      if (N_SRC != NSRC) begin : g_bad_nsrc
         $error("irq_prio_ctrl: source grouping is fixed at %0d sources", NSRC);
      end
      if (N_SRC > RW - 2) begin : g_bad_width
         $error("irq_prio_ctrl: register too narrow for sources plus master");
      end
   endgenerate

   logic [N_SRC-1:0] rise;
   logic [RW-1:0]    rise_w;

   irq_edge_detect #(.N(N_SRC), .EDGE_MODE(EDGE_MODE)) u_edge (
      .clk(clk), .rst_n(rst_n), .lines(src_irq), .hit(rise));

   assign rise_w = RW'(rise);

   irq_setclr_reg #(.W(RW), .VALID(SRC_MASK)) u_req (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en && !wr_sel), .wr_set(wr_set),
      .wr_mask(wr_data), .hw_set(rise_w), .q(req_rd));

   irq_setclr_reg #(.W(RW), .VALID(ENA_MASK)) u_ena (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en && wr_sel), .wr_set(wr_set),
      .wr_mask(wr_data), .hw_set({RW{1'b0}}), .q(ena_rd));

   assign act_rd = req_rd & ena_rd;

   irq_level_encoder #(.N_SRC(N_SRC), .LVLS(TOP_LVL), .OUT_W(IPL_W)) u_enc (
      .clk(clk), .rst_n(rst_n), .pend(act_rd[N_SRC-1:0]),
      .master(ena_rd[MBIT]), .ipl(ipl));

   // R1/R9: the active view never shows a bit absent from either register
   assert_active_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((act_rd & ~req_rd) == '0) && ((act_rd & ~ena_rd) == '0));
   // R3: a write to the enable register leaves requests untouched unless a source rises
   assert_sel_isolation_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && rise == '0) |=> (req_rd == $past(req_rd)));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] src_irq = '0;
   logic        wr_en = 1'b0, wr_sel = 1'b0, wr_set = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] req_rd, ena_rd, act_rd;
   logic [2:0]  ipl;
   int total = 0, bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   irq_prio_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_set(wr_set), .wr_data(wr_data),
      .req_rd(req_rd), .ena_rd(ena_rd), .act_rd(act_rd), .ipl(ipl));

   function automatic int lvl_of(input int i);
      if (i < 3) return 1;
      if (i == 3) return 2;
      if (i < 7) return 3;
      if (i < 11) return 4;
      if (i < 13) return 5;
      return 6;
   endfunction

   function automatic int expect_ipl(input logic [13:0] pend, input bit m);
      int best = 0;
      if (!m) return 0;
      for (int i = 0; i < 14; i++)
         if (pend[i] && lvl_of(i) > best) best = lvl_of(i);
      return best;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive at falling edge, release at next falling edge
   task automatic wr(input bit sel, input bit set, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_set = set; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 req", req_rd, 0);
      check("R1 ena", ena_rd, 0);
      check("R1 ipl", ipl, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 act", act_rd, 0);

      // R9: unused bits
      wr(1'b0, 1'b1, 16'hFFFF);
      check("R9 req", req_rd, 16'h3FFF);
      wr(1'b1, 1'b1, 16'hFFFF);
      check("R9 ena", ena_rd, 16'hBFFF);
      wr(1'b0, 1'b0, 16'hFFFF);
      check("R3 clear all", req_rd, 0);

      // R3: partial clear leaves other bits
      wr(1'b1, 1'b0, 16'h00F0);
      check("R3 partial", ena_rd, 16'hBF0F);
      wr(1'b1, 1'b1, 16'h00F0);
      check("R3 set back", ena_rd, 16'hBFFF);

      // R8 / R5: exhaustive sweep, everything enabled
      for (int p = 0; p < 16384; p++) begin
         wr(1'b0, 1'b1, 16'(p));
         check("R5 sweep req", req_rd, p);
         check("R5 sweep act", act_rd, p);
         check("R8 sweep ipl", ipl, expect_ipl(14'(p), 1'b1));
         wr(1'b0, 1'b0, 16'h3FFF);
      end

      // R7: one enable at a time against full request set
      wr(1'b0, 1'b1, 16'h3FFF);
      for (int i = 0; i < 14; i++) begin
         wr(1'b1, 1'b0, 16'hFFFF);
         wr(1'b1, 1'b1, 16'h8000 | 16'(1 << i));
         check("R7 level map", ipl, lvl_of(i));
         check("R5 single act", act_rd, 1 << i);
      end

      // R6: master off
      wr(1'b1, 1'b1, 16'h3FFF);
      wr(1'b1, 1'b0, 16'h8000);
      for (int i = 0; i < 14; i++) begin
         wr(1'b0, 1'b0, 16'h3FFF);
         wr(1'b0, 1'b1, 16'(1 << i));
         check("R6 master off ipl", ipl, 0);
         check("R5 act master off", act_rd, 1 << i);
      end
      wr(1'b0, 1'b0, 16'h3FFF);

      // R2: rise sets request with enables off
      wr(1'b1, 1'b0, 16'hFFFF);
      @(negedge clk); src_irq = 14'h0200;
      @(negedge clk);
      check("R2 rise sets", req_rd, 16'h0200);
      check("R2 ipl disabled", ipl, 0);
      wr(1'b0, 1'b0, 16'h0200);
      repeat (2) @(negedge clk);
      check("R2 held no reset", req_rd, 0);
      src_irq = '0;
      @(negedge clk);

      // R4: rise and clear in same cycle
      wr(1'b0, 1'b1, 16'h2000);
      @(negedge clk);
      src_irq = 14'h2000;
      wr_en = 1'b1; wr_sel = 1'b0; wr_set = 1'b0; wr_data = 16'h2000;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      check("R4 rise beats clear", req_rd, 16'h2000);
      wr(1'b1, 1'b1, 16'hA000);
      check("R8 top level", ipl, 6);
      src_irq = '0;

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule